// File: doc/BRIEF.md
# Bit-Serial Partial-Product Recombiner

This unit rebuilds one full-precision output component of a bit-serial binary vector-matrix array from its quantized partial outputs. The array stores each weight in `WB` bit-planes, which are the rows here. It takes one input-vector bit per step over `XB` steps, least significant input bit first. For every step a flash converter on each bit-plane row delivers a 6-bit code in Gray form. The recombiner turns each code into binary and, if asked, subtracts the matching code of a reference channel that holds all-zero weights. The difference is clamped at zero. Each corrected partial then goes to the diagonal group for its combined significance. When the last step has been accepted, the groups are weighted by powers of two and added into one fixed-point result word.

The result carries a fixed scale. It equals the true fractional value, in which a partial of row i from step t weighs 2^-(i + (XB-1-t) + 2), multiplied by 2^(WB+XB). No rounding is ever needed. A `start` pulse opens a job. The unit then accepts `XB` beats, each marked by `in_valid`, and gaps between beats are allowed. `out_valid` and `result` then hold until the next `start`.

Top module: `rec_vmm_recomb`

## Requirements
- R1: Each 6-bit lane code is read as Gray code: binary bit n is the XOR of code bits n and above. Lane i occupies bits [i*QW +: QW] of `part_codes`, and the reference lane i sits at the same position in `ref_codes`.
- R2: A `start` pulse clears all group sums. In the cycle after it, `busy` is 1 and `out_valid` is 0.
- R3: After `start`, exactly `XB` beats are accepted, one at each rising edge where `in_valid` is 1 while `busy` is 1. After the edge that accepts beat `XB`-1, `busy` is 0 and `out_valid` is 1.
- R4: With `sub_en` at 0, `result` equals the sum over rows i and beats t of the decoded partial shifted left by (WB-1-i)+t. Row 0 is the most significant weight bit, and beat 0 carries the least significant input bit.
- R5: The partials are summed by diagonal index d = (WB-1-i)+t, which runs from 0 to WB+XB-2. `result` is the sum of group d shifted left by d.
- R6: With `sub_en` at 1 during a beat, each partial of that beat becomes max(0, decoded part - decoded reference) before accumulation.
- R7: With `sub_en` at 0 during a beat, the reference codes of that beat have no effect on `result`.
- R8: `in_valid` while `busy` is 0 is ignored. `result` and `out_valid` hold until the next `start`.
- R9: Cycles with `in_valid` at 0 during a job leave the group sums unchanged and do not count as beats.
- R10: All partials at 63 produce 63*(2^WB-1)*(2^XB-1) without overflow. The output is QW+WB+XB bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Opens a new job and clears the accumulators |
| in_valid | input | 1 | The lane codes form one beat |
| sub_en | input | 1 | Subtract the reference lanes during this beat |
| part_codes | input | WB*QW | Gray-coded partials, one per bit-plane row |
| ref_codes | input | WB*QW | Gray-coded reference-channel partials |
| busy | output | 1 | A job is open and beats are still expected |
| out_valid | output | 1 | `result` is complete |
| result | output | QW+WB+XB | Recombined fixed-point result |

## Verification
The bench builds the unit with WB = XB = 4 and QW = 6. This gives seven diagonal groups and group populations from one to four partials. The largest output is 14175, so an all-63 job reaches the top of the 14-bit result. A lone nonzero partial on the least significant diagonal brings each Gray decode straight out to `result`. Jobs with a different pattern per row and beat, with stalls, with reference lanes above and below the main lanes, and with `sub_en` switched between beats cover the clamp, the subtraction and the reference lanes that have no effect.

// File: rtl/rec_pkg.sv
package rec_pkg;

  // Prefix XOR from the top bit down: Gray code to binary
  function automatic int unsigned gray_to_bin(input int unsigned g);
    int unsigned b;
    b = g;
    for (int s = 1; s < 32; s = s * 2) b = b ^ (b >> s);
    return b;
  endfunction

  // Signed difference clamped at zero
  function automatic int unsigned sub_floor0(input int unsigned a, input int unsigned r);
    return (a > r) ? (a - r) : 0;
  endfunction

endpackage

// File: rtl/rec_lane.sv
module rec_lane #(
  parameter int QW = 6
) (
  input  logic [QW-1:0] code,
  input  logic [QW-1:0] ref_code,
  input  logic          sub_en,
  output logic [QW-1:0] corr
);
  import rec_pkg::*;

  logic [QW-1:0] main_bin;
  logic [QW-1:0] ref_bin;

  always_comb begin
    main_bin = QW'(gray_to_bin(32'(code)));
    ref_bin  = QW'(gray_to_bin(32'(ref_code)));
    corr     = sub_en ? QW'(sub_floor0(32'(main_bin), 32'(ref_bin))) : main_bin;
  end

  // R6
  always_comb clamp_le_chk: assert (corr <= main_bin);

endmodule

// File: rtl/rec_diag_acc.sv
module rec_diag_acc #(
  parameter int WB = 4,
  parameter int XB = 4,
  parameter int QW = 6,
  parameter int GW = 9,
  parameter int CW = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             acc_en,
  input  logic [CW-1:0]    beat,
  input  logic [WB*QW-1:0] lanes,
  output logic [(WB+XB-1)*GW-1:0] groups
);
  localparam int K = WB + XB - 1;

  logic [K*GW-1:0] groups_q;

  for (genvar d = 0; d < K; d++) begin : g_diag
    logic [GW-1:0] add;
    always_comb begin
      add = '0;
      for (int i = 0; i < WB; i++) begin
        if ((WB - 1 - i) + int'(beat) == d) add = add + GW'(lanes[i*QW +: QW]);
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      groups_q[d*GW +: GW] <= '0;
      else if (clr)    groups_q[d*GW +: GW] <= '0;
      else if (acc_en) groups_q[d*GW +: GW] <= groups_q[d*GW +: GW] + add;
    end
  end

  assign groups = groups_q;

  // R9
  group_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_en && !clr) |=> $stable(groups_q));

endmodule

// File: rtl/rec_combine.sv
module rec_combine #(
  parameter int K  = 7,
  parameter int GW = 9,
  parameter int OW = 14
) (
  input  logic [K*GW-1:0] groups,
  output logic [OW-1:0]   result
);
  always_comb begin
    result = '0;
    for (int d = 0; d < K; d++) result = result + (OW'(groups[d*GW +: GW]) << d);
  end
endmodule

// File: rtl/rec_vmm_recomb.sv
module rec_vmm_recomb #(
  parameter int WB = 4,
  parameter int XB = 4,
  parameter int QW = 6,
  localparam int K  = WB + XB - 1,
  localparam int OW = QW + WB + XB,
  localparam int GW = QW + $clog2(WB + 1),
  localparam int CW = (XB > 1) ? $clog2(XB) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             in_valid,
  input  logic             sub_en,
  input  logic [WB*QW-1:0] part_codes,
  input  logic [WB*QW-1:0] ref_codes,
  output logic             busy,
  output logic             out_valid,
  output logic [OW-1:0]    result
);
  logic [CW-1:0]    beat_q;
  logic             busy_q;
  logic             done_q;
  logic             accept;
  logic             last_beat;
  logic [WB*QW-1:0] lanes;
  logic [K*GW-1:0]  groups;

  assign accept    = in_valid && busy_q && !start;
  assign last_beat = (int'(beat_q) == XB - 1);

  for (genvar i = 0; i < WB; i++) begin : g_lane
    rec_lane #(.QW(QW)) u_lane (
      .code     (part_codes[i*QW +: QW]),
      .ref_code (ref_codes[i*QW +: QW]),
      .sub_en   (sub_en),
      .corr     (lanes[i*QW +: QW])
    );
  end

  rec_diag_acc #(.WB(WB), .XB(XB), .QW(QW), .GW(GW), .CW(CW)) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (start),
    .acc_en (accept),
    .beat   (beat_q),
    .lanes  (lanes),
    .groups (groups)
  );

  rec_combine #(.K(K), .GW(GW), .OW(OW)) u_comb (
    .groups (groups),
    .result (result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start) begin
      beat_q <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (accept) begin
      if (last_beat) begin
        beat_q <= '0;
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  assign busy      = busy_q;
  assign out_valid = done_q;

  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !out_valid));

  // R3
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && last_beat) |=> (out_valid && !busy));

  // R3
  beat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(beat_q) < XB);

  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !start) |=> (out_valid && $stable(result)));

  // R8
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(start));

endmodule

// File: tb/test_rec_vmm_recomb.sv
module test_rec_vmm_recomb;
  localparam int WB = 4;
  localparam int XB = 4;
  localparam int QW = 6;
  localparam int OW = QW + WB + XB;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             in_valid = 1'b0;
  logic             sub_en = 1'b0;
  logic [WB*QW-1:0] part_codes = '0;
  logic [WB*QW-1:0] ref_codes = '0;
  logic             busy;
  logic             out_valid;
  logic [OW-1:0]    result;

  int errors = 0;
  int checks = 0;

  int yv [XB][WB];
  int rv [XB][WB];
  bit sv [XB];

  always #2 clk = ~clk;

  rec_vmm_recomb #(.WB(WB), .XB(XB), .QW(QW)) i_rec_vmm_recomb (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .sub_en(sub_en),
    .part_codes(part_codes), .ref_codes(ref_codes),
    .busy(busy), .out_valid(out_valid), .result(result)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int to_gray(input int b);
    return b ^ (b >> 1);
  endfunction

  // Model: per beat a row value with row 0 heaviest, then weighted by 2^t
  function automatic int model();
    int total = 0;
    for (int t = 0; t < XB; t++) begin
      int row = 0;
      for (int i = 0; i < WB; i++) begin
        int c = yv[t][i];
        if (sv[t]) c = (yv[t][i] > rv[t][i]) ? yv[t][i] - rv[t][i] : 0;
        row = row * 2 + c;
      end
      total = total + row * (1 << t);
    end
    return total;
  endfunction

  task automatic clear_pattern();
    for (int t = 0; t < XB; t++) begin
      sv[t] = 1'b0;
      for (int i = 0; i < WB; i++) begin yv[t][i] = 0; rv[t][i] = 0; end
    end
  endtask

  task automatic run_job(input string req, input int gap);
    int exp;
    exp = model();
    start = 1'b1;
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1 && out_valid === 1'b0, "R2", {busy, out_valid}, 2);
    for (int t = 0; t < XB; t++) begin
      for (int g = 0; g < gap; g++) begin
        part_codes = '1; ref_codes = '0; sub_en = 1'b0;
        @(posedge clk); @(negedge clk);
      end
      for (int i = 0; i < WB; i++) begin
        part_codes[i*QW +: QW] = QW'(to_gray(yv[t][i]));
        ref_codes[i*QW +: QW]  = QW'(to_gray(rv[t][i]));
      end
      sub_en = sv[t];
      in_valid = 1'b1;
      @(posedge clk); @(negedge clk);
      in_valid = 1'b0;
      if (t < XB - 1) check(out_valid === 1'b0, "R3", int'(out_valid), 0);
    end
    check(out_valid === 1'b1 && busy === 1'b0, "R3", {out_valid, busy}, 2);
    check(int'(result) == exp, req, int'(result), exp);
  endtask

  task automatic t_reset();
    check(out_valid === 1'b0 && busy === 1'b0, "R2 reset", {busy, out_valid}, 0);
    check(result === '0, "R2 reset result", int'(result), 0);
  endtask

  task automatic t_gray();
    int vals [5] = '{1, 2, 5, 32, 63};
    foreach (vals[n]) begin
      clear_pattern();
      yv[0][WB-1] = vals[n];
      run_job("R1", 0);
    end
  endtask

  task automatic t_weights();
    for (int s = 0; s < 3; s++) begin
      clear_pattern();
      for (int t = 0; t < XB; t++)
        for (int i = 0; i < WB; i++) yv[t][i] = (t * 17 + i * 29 + s * 11) % 64;
      run_job("R4", 0);
    end
    clear_pattern();
    yv[0][0] = 1; yv[XB-1][WB-1] = 1; yv[1][1] = 3;
    run_job("R5", 0);
  endtask

  task automatic t_sub();
    clear_pattern();
    for (int t = 0; t < XB; t++) begin
      sv[t] = 1'b1;
      for (int i = 0; i < WB; i++) begin
        yv[t][i] = (t * 13 + i * 7 + 20) % 64;
        rv[t][i] = (i % 2 == 0) ? 5 : 60;
      end
    end
    run_job("R6", 0);
    for (int t = 0; t < XB; t++) sv[t] = (t % 2 == 1);
    run_job("R6 R7 mixed", 0);
    for (int t = 0; t < XB; t++) sv[t] = 1'b0;
    run_job("R7", 0);
  endtask

  task automatic t_idle_and_stall();
    int held;
    clear_pattern();
    for (int t = 0; t < XB; t++)
      for (int i = 0; i < WB; i++) yv[t][i] = (t + 3 * i + 1) % 64;
    run_job("R9", 2);
    held = int'(result);
    part_codes = '1; in_valid = 1'b1;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    in_valid = 1'b0;
    check(int'(result) == held && out_valid === 1'b1, "R8", int'(result), held);
  endtask

  task automatic t_max();
    clear_pattern();
    for (int t = 0; t < XB; t++)
      for (int i = 0; i < WB; i++) yv[t][i] = 63;
    run_job("R10", 0);
    check(int'(result) == 63 * ((1 << WB) - 1) * ((1 << XB) - 1), "R10 bound",
          int'(result), 63 * ((1 << WB) - 1) * ((1 << XB) - 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gray();
    t_weights();
    t_sub();
    t_idle_and_stall();
    t_max();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule